// File: doc/BRIEF.md
# Compare-and-Skip Execute Slice

This block executes the two compare-and-skip operations of an 8-bit accumulator core. One operation skips the next instruction when a file register is greater than the working register. The other skips it when the file register is less. Each instruction cycle has four phases, and the phase index comes in on `q_ph`. The slice latches the instruction word at the end of the first phase and forms a 12-bit data address from the 8-bit file field, the access bit, the bank select value and an optional indexed base. It reads the operand in the second phase, and in the third phase it subtracts the working register from it as unsigned values.

When the condition holds, the slice raises `skip_req` in the fourth phase. The fetch stage then replaces the prefetched word with a no-op. The slice also tracks how many of the following instruction cycles are discarded. That is one cycle for a one-word follower and two for a two-word follower. A follower is two words long when its top nibble selects a set bit of the `tw_mask` input. No status flag is touched by either operation.

Top module: `cmpskip_exec`

## Requirements
- R1: An instruction word is a compare only when bits 15:9 equal 0110010 (greater-than) or 0110000 (less-than). Bit 8 is the access bit and bits 7:0 are the file field. Any other word causes no read and no skip.
- R2: `q_ph` counts 0,1,2,3 (phases one to four), advancing once per clock. A compare is accepted at the end of phase one while `instr_valid` is high. `rf_rd_en` is high only during phase two of an accepted compare, and `rf_rdata` is captured at the end of that phase.
- R3: With access bit 1, `rf_addr` equals {`bank_sel`, file field}.
- R4: With access bit 0 and `ext_mode` low, `rf_addr` is 0x000 plus the file field when the field is below 0x60. Otherwise it is 0xF00 plus the field.
- R5: With access bit 0 and `ext_mode` high, a file field of 0x5F or less gives `rf_addr` = (`idx_base` + field) mod 4096. Fields of 0x60 and above map as in R4.
- R6: The greater-than compare skips exactly when the operand is above `w_reg`, taken as unsigned values.
- R7: The less-than compare skips exactly when the operand is below `w_reg`, taken as unsigned values. Equal operands never skip in either compare.
- R8: `skip_req` is high during phase four of a compare cycle whose condition holds, and is low at all other times.
- R9: After a skip, `nop_slot` is high for all four phases of each discarded cycle. A skip over a one-word follower takes 2 cycles in total, a skip over a two-word follower takes 3 cycles, and a compare that does not skip takes 1 cycle.
- R10: The follower is two words long when `tw_mask[next_word_hi]` is 1, sampled in phase three. `skip_2w` is high during the first discarded cycle of a two-word skip and low otherwise.
- R11: While `nop_slot` is high, an instruction word offered with `instr_valid` is ignored: no read and no skip.
- R12: While `rst_n` is low, `rf_rd_en`, `skip_req`, `nop_slot` and `skip_2w` are low. An asserted reset clears a pending discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_ph | input | 2 | Current phase index, 0 to 3 |
| instr_valid | input | 1 | Instruction word present in phase one |
| instr | input | 16 | Instruction word |
| w_reg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank select, upper address bits for access bit 1 |
| ext_mode | input | 1 | Extended indexed mode enable |
| idx_base | input | 12 | Base address for indexed offsets |
| next_word_hi | input | 4 | Top nibble of the prefetched follower word |
| tw_mask | input | 16 | One bit per nibble value marking two-word opcodes |
| rf_rdata | input | 8 | Register file read data |
| rf_addr | output | 12 | Register file read address |
| rf_rd_en | output | 1 | Register file read strobe |
| skip_req | output | 1 | Discard request to fetch, phase four |
| nop_slot | output | 1 | Current instruction cycle is discarded |
| skip_2w | output | 1 | First of two discarded cycles |

## Verification
The assertions assume that `q_ph` steps by exactly one every clock, with no holds or jumps, and that it keeps counting during reset. The bench drives the phase from the same task that advances the clock, so that rule is never broken, even across the mid-run reset. The assertions also assume that `rf_rdata` is valid in phase two. The bench's read data is a plain value that it sets before phase one and holds through the read. Instruction words are changed only on phase boundaries, the way a fetch stage would change them.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_GT   = 2'd1,
    OP_LT   = 2'd2
  } cmp_op_e;

  localparam int          INSTR_W = 16;
  localparam int          OPC_W   = 7;
  localparam logic [6:0]  OPC_GT  = 7'b0110010;
  localparam logic [6:0]  OPC_LT  = 7'b0110000;

endpackage

// File: rtl/cmpskip_decode.sv
module cmpskip_decode
  import cmpskip_pkg::*;
#(
  parameter int              FW        = 8,
  parameter int              BW        = 4,
  parameter logic [FW-1:0]   ACC_SPLIT = 8'h60,
  parameter logic [FW-1:0]   LIT_MAX   = 8'h5F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           q_ph,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 hold,
  input  logic [BW-1:0]        bank_sel,
  input  logic                 ext_mode,
  input  logic [FW+BW-1:0]     idx_base,
  output cmp_op_e              op_o,
  output logic [FW+BW-1:0]     addr_o
);

  localparam int             AW       = FW + BW;
  localparam logic [BW-1:0]  SFR_BANK = {BW{1'b1}};
  localparam logic [BW-1:0]  LOW_BANK = {BW{1'b0}};

  qphase_e              ph;
  logic [FW-1:0]        ffield;
  logic                 abit;
  logic [OPC_W-1:0]     opc;
  cmp_op_e              op_dec;
  logic [AW-1:0]        addr_dec;
  cmp_op_e              op_d, op_q;
  logic [AW-1:0]        addr_d, addr_q;
  logic                 latch_en;

  assign ph     = qphase_e'(q_ph);
  assign ffield = instr[FW-1:0];
  assign abit   = instr[FW];
  assign opc    = instr[INSTR_W-1:FW+1];

  // opcode field
  always_comb begin
    if (opc == OPC_GT)      op_dec = OP_GT;
    else if (opc == OPC_LT) op_dec = OP_LT;
    else                    op_dec = OP_NONE;
  end

  // effective data address
  always_comb begin
    if (abit)
      addr_dec = {bank_sel, ffield};
    else if (ext_mode && (ffield <= LIT_MAX))
      addr_dec = idx_base + {LOW_BANK, ffield};
    else if (ffield < ACC_SPLIT)
      addr_dec = {LOW_BANK, ffield};
    else
      addr_dec = {SFR_BANK, ffield};
  end

  assign latch_en = (ph == PH_Q1);

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    if (latch_en) begin
      op_d   = (instr_valid && !hold) ? op_dec : OP_NONE;
      addr_d = addr_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
    end else if (latch_en) begin
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;

  // R1
  foreign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q1 && instr_valid && opc != OPC_GT && opc != OPC_LT) |=> (op_q == OP_NONE));

  // R11
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q1 && hold) |=> (op_q == OP_NONE));

endmodule

// File: rtl/cmpskip_compare.sv
module cmpskip_compare
  import cmpskip_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           q_ph,
  input  cmp_op_e              op_i,
  input  logic [DW-1:0]        w_reg,
  input  logic [DW-1:0]        rf_rdata,
  input  logic [PW-1:0]        next_hi,
  input  logic [(1<<PW)-1:0]   tw_mask,
  output logic                 rd_en_o,
  output logic                 cond_o,
  output logic                 tw_o
);

  localparam int NPFX = 1 << PW;

  qphase_e          ph;
  logic [DW-1:0]    opnd_d, opnd_q;
  logic [DW:0]      diff;
  logic             borrow, zero, hit;
  logic             cond_d, cond_q;
  logic             tw_d, tw_q;
  logic [NPFX-1:0]  pfx_hit;
  logic             rd_en;

  assign ph = qphase_e'(q_ph);

  for (genvar k = 0; k < NPFX; k++) begin : g_pfx
    assign pfx_hit[k] = tw_mask[k] & (next_hi == PW'(k));
  end

  assign rd_en = (op_i != OP_NONE) && (ph == PH_Q2);

  // subtraction: operand minus working register
  always_comb begin
    diff   = {1'b0, opnd_q} - {1'b0, w_reg};
    borrow = diff[DW];
    zero   = (diff[DW-1:0] == '0);
    case (op_i)
      OP_GT:   hit = !borrow && !zero;
      OP_LT:   hit = borrow;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    opnd_d = rd_en ? rf_rdata : opnd_q;
    cond_d = cond_q;
    tw_d   = tw_q;
    if (ph == PH_Q3) begin
      cond_d = hit;
      tw_d   = |pfx_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      cond_q <= 1'b0;
      tw_q   <= 1'b0;
    end else begin
      if (rd_en)         opnd_q <= opnd_d;
      if (ph == PH_Q3) begin
        cond_q <= cond_d;
        tw_q   <= tw_d;
      end
    end
  end

  assign rd_en_o = rd_en;
  assign cond_o  = cond_q;
  assign tw_o    = tw_q;

  // R7
  equal_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q3 && opnd_q == w_reg) |=> !cond_q);

  // R6
  gt_needs_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q3 && op_i == OP_GT && opnd_q < w_reg) |=> !cond_q);

  // R2
  rd_only_q2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (ph == PH_Q2));

endmodule

// File: rtl/cmpskip_skipctl.sv
module cmpskip_skipctl
  import cmpskip_pkg::*;
#(
  parameter int MAX_DROP = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  q_ph,
  input  logic        cond_i,
  input  logic        tw_i,
  output logic        skip_req_o,
  output logic        nop_slot_o,
  output logic        skip_2w_o
);

  localparam int CW = $clog2(MAX_DROP + 1);
  localparam logic [CW-1:0] ONE_DROP = CW'(1);
  localparam logic [CW-1:0] ALL_DROP = CW'(MAX_DROP);

  qphase_e        ph;
  logic [CW-1:0]  slots_d, slots_q;
  logic           skip_req;

  assign ph       = qphase_e'(q_ph);
  assign skip_req = cond_i && (ph == PH_Q4);

  always_comb begin
    slots_d = slots_q;
    if (ph == PH_Q4) begin
      if (skip_req)
        slots_d = tw_i ? ALL_DROP : ONE_DROP;
      else if (slots_q != '0)
        slots_d = slots_q - ONE_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slots_q <= '0;
    else if (ph == PH_Q4)
      slots_q <= slots_d;
  end

  assign skip_req_o = skip_req;
  assign nop_slot_o = (slots_q != '0);
  assign skip_2w_o  = (slots_q == ALL_DROP);

  // R9
  skip_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |=> nop_slot_o);

  // R9
  nop_rise_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nop_slot_o) |-> (ph == PH_Q1));

  // R9
  nop_fall_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nop_slot_o) |-> (ph == PH_Q1));

  // R10
  two_word_in_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_2w_o |-> nop_slot_o);

  // R8
  skip_q4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (ph == PH_Q4));

endmodule

// File: rtl/cmpskip_exec.sv
module cmpskip_exec
  import cmpskip_pkg::*;
#(
  parameter int             FW        = 8,
  parameter int             BW        = 4,
  parameter int             DW        = 8,
  parameter int             PW        = 4,
  parameter logic [FW-1:0]  ACC_SPLIT = 8'h60,
  parameter logic [FW-1:0]  LIT_MAX   = 8'h5F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           q_ph,
  input  logic                 instr_valid,
  input  logic [15:0]          instr,
  input  logic [DW-1:0]        w_reg,
  input  logic [BW-1:0]        bank_sel,
  input  logic                 ext_mode,
  input  logic [FW+BW-1:0]     idx_base,
  input  logic [PW-1:0]        next_word_hi,
  input  logic [(1<<PW)-1:0]   tw_mask,
  input  logic [DW-1:0]        rf_rdata,
  output logic [FW+BW-1:0]     rf_addr,
  output logic                 rf_rd_en,
  output logic                 skip_req,
  output logic                 nop_slot,
  output logic                 skip_2w
);

  localparam int MAX_DROP = 2;

  cmp_op_e  op;
  logic     cond, tw;

  cmpskip_decode #(
    .FW(FW), .BW(BW), .ACC_SPLIT(ACC_SPLIT), .LIT_MAX(LIT_MAX)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .q_ph(q_ph),
    .instr_valid(instr_valid), .instr(instr), .hold(nop_slot),
    .bank_sel(bank_sel), .ext_mode(ext_mode), .idx_base(idx_base),
    .op_o(op), .addr_o(rf_addr)
  );

  cmpskip_compare #(.DW(DW), .PW(PW)) u_compare (
    .clk(clk), .rst_n(rst_n), .q_ph(q_ph), .op_i(op),
    .w_reg(w_reg), .rf_rdata(rf_rdata),
    .next_hi(next_word_hi), .tw_mask(tw_mask),
    .rd_en_o(rf_rd_en), .cond_o(cond), .tw_o(tw)
  );

  cmpskip_skipctl #(.MAX_DROP(MAX_DROP)) u_skipctl (
    .clk(clk), .rst_n(rst_n), .q_ph(q_ph),
    .cond_i(cond), .tw_i(tw),
    .skip_req_o(skip_req), .nop_slot_o(nop_slot), .skip_2w_o(skip_2w)
  );

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_ph == $past(q_ph) + 2'd1);

  // R11
  no_read_in_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_slot |-> !rf_rd_en);

endmodule

// File: tb/cmpskip_exec_tb.sv
module cmpskip_exec_tb;
  import cmpskip_pkg::*;

  logic        clk, rst_n;
  logic [1:0]  ph;
  logic        instr_valid;
  logic [15:0] instr;
  logic [7:0]  w_reg, rf_rdata;
  logic [3:0]  bank_sel, next_word_hi;
  logic        ext_mode;
  logic [11:0] idx_base, rf_addr;
  logic [15:0] tw_mask;
  logic        rf_rd_en, skip_req, nop_slot, skip_2w;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cmpskip_exec u_dut (
    .clk(clk), .rst_n(rst_n), .q_ph(ph), .instr_valid(instr_valid),
    .instr(instr), .w_reg(w_reg), .bank_sel(bank_sel), .ext_mode(ext_mode),
    .idx_base(idx_base), .next_word_hi(next_word_hi), .tw_mask(tw_mask),
    .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
    .skip_req(skip_req), .nop_slot(nop_slot), .skip_2w(skip_2w)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: gt a ext f w bank idx data nib cycles
  localparam int NV = 17;
  localparam logic [48:0] VECS [0:NV-1] = '{
    {1'b1,1'b1,1'b0,8'h10,8'h00,4'h2,12'h000,8'h01,4'h0,2'd2},
    {1'b1,1'b1,1'b0,8'h11,8'h01,4'h3,12'h000,8'h01,4'h0,2'd1},
    {1'b0,1'b1,1'b0,8'h12,8'h01,4'h4,12'h000,8'h01,4'h0,2'd1},
    {1'b1,1'b1,1'b0,8'h13,8'h7F,4'h5,12'h000,8'h80,4'h0,2'd2},
    {1'b0,1'b1,1'b0,8'h14,8'h80,4'h6,12'h000,8'h7F,4'h0,2'd2},
    {1'b0,1'b1,1'b0,8'h15,8'h7F,4'h7,12'h000,8'h80,4'h0,2'd1},
    {1'b1,1'b1,1'b0,8'hFE,8'hFE,4'h8,12'h000,8'hFF,4'hC,2'd3},
    {1'b0,1'b1,1'b0,8'hFF,8'hFF,4'h9,12'h000,8'h00,4'hF,2'd3},
    {1'b1,1'b1,1'b0,8'h80,8'hFF,4'hA,12'h000,8'hFE,4'hE,2'd1},
    {1'b0,1'b1,1'b0,8'h7F,8'hFF,4'hB,12'h000,8'hFF,4'h0,2'd1},
    {1'b1,1'b1,1'b0,8'h00,8'h00,4'h1,12'h000,8'h00,4'h0,2'd1},
    {1'b1,1'b0,1'b0,8'h5F,8'h00,4'h2,12'h000,8'h80,4'h0,2'd2},
    {1'b0,1'b0,1'b0,8'h60,8'h01,4'h2,12'h000,8'h00,4'h0,2'd2},
    {1'b1,1'b0,1'b1,8'h5F,8'h00,4'h2,12'h100,8'hFF,4'hD,2'd2},
    {1'b0,1'b0,1'b1,8'h60,8'h02,4'h2,12'h100,8'h01,4'hE,2'd3},
    {1'b1,1'b1,1'b1,8'h00,8'h01,4'hF,12'h300,8'h02,4'h0,2'd2},
    {1'b0,1'b0,1'b1,8'h00,8'h80,4'h2,12'hFFF,8'h00,4'h0,2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 ph = ph + 2'd1;
  endtask

  task automatic to_q1();
    while (ph != 2'd0) tick();
  endtask

  function automatic logic [11:0] exp_addr(input logic a, input logic ext,
      input logic [7:0] f, input logic [3:0] bs, input logic [11:0] base);
    if (a)                     return {bs, f};
    if (ext && f <= 8'h5F)     return base + {4'h0, f};
    if (f < 8'h60)             return {4'h0, f};
    return {4'hF, f};
  endfunction

  task automatic run_vec(input logic [48:0] v);
    logic gt, a, ext, exp_skip;
    logic [7:0] f, w, d;
    logic [3:0] bs, nib;
    logic [11:0] base;
    logic [1:0] cyc;
    int cnt;
    {gt, a, ext, f, w, bs, base, d, nib, cyc} = v;
    exp_skip = gt ? (d > w) : (d < w);
    to_q1();
    instr = {(gt ? OPC_GT : OPC_LT), a, f};
    instr_valid = 1'b1; w_reg = w; bank_sel = bs; ext_mode = ext;
    idx_base = base; rf_rdata = d; next_word_hi = nib;
    tick(); #5;
    chk("R2 read strobe", rf_rd_en, 1);
    chk(a ? "R3 addr" : (ext ? "R5 addr" : "R4 addr"), rf_addr, exp_addr(a, ext, f, bs, base));
    instr_valid = 1'b0;
    tick(); tick(); #5;
    chk(gt ? "R6 skip" : "R7 skip", skip_req, exp_skip);
    cnt = 1;
    for (int k = 0; k < 3; k++) begin
      tick(); #5;
      if (nop_slot) cnt++;
      chk("R10 skip_2w", skip_2w, (k == 0 && cyc == 2'd3));
      tick(); tick(); tick();
    end
    chk("R9 cycles", cnt, cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ph = 2'd0; instr_valid = 1'b0; instr = '0; w_reg = '0;
    rf_rdata = '0; bank_sel = '0; ext_mode = 1'b0; idx_base = '0;
    next_word_hi = '0; tw_mask = 16'hD000;  // nibbles C, E, F are two-word
    repeat (6) tick();
    #5;
    chk("R12 reset rd", rf_rd_en, 0);
    chk("R12 reset skip", skip_req, 0);
    chk("R12 reset nop", {nop_slot, skip_2w}, 0);
    tick();
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: non-compare word 0x62xx
    to_q1();
    instr = 16'h6210; instr_valid = 1'b1; rf_rdata = 8'hFF; w_reg = 8'h00;
    tick(); #5;
    chk("R1 foreign read", rf_rd_en, 0);
    instr_valid = 1'b0;
    tick(); tick(); #5;
    chk("R1 foreign skip", skip_req, 0);
    tick(); #5;
    chk("R1 foreign nop", nop_slot, 0);

    // R11: valid held into the discarded cycle
    to_q1();
    instr = {OPC_GT, 1'b1, 8'h20}; instr_valid = 1'b1; bank_sel = 4'h1;
    rf_rdata = 8'hFF; w_reg = 8'h00; next_word_hi = 4'h0;
    tick(); tick(); tick(); #5;
    chk("R8 skip raised", skip_req, 1);
    tick(); #5;
    chk("R11 in nop", nop_slot, 1);
    tick(); #5;
    chk("R11 no read", rf_rd_en, 0);
    tick(); tick(); #5;
    chk("R11 no skip", skip_req, 0);
    instr_valid = 1'b0;
    tick(); #5;
    chk("R11 nop ends", nop_slot, 0);

    // R12: reset clears a pending discard
    to_q1();
    instr = {OPC_LT, 1'b1, 8'h21}; instr_valid = 1'b1;
    rf_rdata = 8'h00; w_reg = 8'h01; next_word_hi = 4'hF;
    tick(); instr_valid = 1'b0; tick(); tick();
    tick(); #5;
    chk("R10 two-word flag", skip_2w, 1);
    rst_n = 1'b0; #1;
    chk("R12 reset clears", {nop_slot, skip_2w, skip_req}, 0);
    tick(); tick();
    rst_n = 1'b1;
    tick(); #5;
    chk("R12 after reset", nop_slot, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule